// File: doc/BRIEF.md
# Static Memory Bank Chip-Select Controller

This block sits between a CPU request port and an external static-memory bus. The external bus carries ROM, SRAM or memory-mapped peripherals. The lowest gigabyte of the 32-bit address space is split into eight windows of 128 MB each. Each window owns one active-low chip select. An accepted request to a window runs one bus access on that window. The length of the access, the data width and the use of the external wait input are all set by configuration inputs kept for each window.

The pin address depends on the window's data width:

- For an 8-bit window, the pin address is the byte offset within the window.
- For a 16-bit window, the offset is shifted right by one.
- For a 32-bit window, the offset is shifted right by two.

Window 0 cannot be configured as 8-bit. Requests above the eight windows complete immediately with an error and touch no pins.

The request side is a valid/ready channel. `req_valid` may be raised at any time. The request fields must stay stable while `req_valid` is high and `req_ready` is low. A transfer happens on a clock edge where both are high. While an access is running, `req_ready` stays low, which is the only back-pressure. Completion is a one-cycle `rsp_valid` pulse with no ready of its own, so the consumer must take it in that cycle. The configuration inputs are sampled at the moment of acceptance.

Top module: `stmem_bank_ctrl`

## Requirements
- R1: After reset, all eight chip selects, the read strobe and the write strobe are high. `mem_doe` and `rsp_valid` are low, and `req_ready` is high.
- R2: A request with `req_addr[31:30]` = 0 selects window `req_addr[29:27]`, and only that window's `mem_ncs` bit goes low during the access. A request with `req_addr[31:30]` ≠ 0 gets `rsp_valid`=1 with `rsp_err`=1 in the cycle after acceptance, and no chip select goes low.
- R3: Each window has a width code in `cfg_width[2*b+1:2*b]`: 00 is 8-bit, 01 is 16-bit, and 10 or 11 is 32-bit. `mem_addr` equals `req_addr[26:0]` shifted right by 0, 1 or 2 respectively, with zero fill. It stays constant for the whole access.
- R4: For window 0, width code 00 is treated as 16-bit, so the shift is 1.
- R5: Each window has an access code in `cfg_acc[3*b+2:3*b]`. Codes 0 to 7 give chip-select low times of 1, 2, 3, 4, 6, 8, 10 and 14 clocks. The strobes go low on the acceptance edge.
- R6: On a read, `mem_noe` is low and `mem_nwe` is high for exactly the chip-select window. On a write, `mem_nwe` is low, `mem_noe` is high, `mem_doe` is high and `mem_dout` equals `req_wdata`. Both strobes are high whenever no chip select is low.
- R7: When `cfg_wait_en[b]` is 1, the access ends at the first edge, from the last programmed clock onward, at which `mem_nwait` is high. When `cfg_wait_en[b]` is 0, `mem_nwait` has no effect on the length.
- R8: `req_ready` is low for exactly the clocks during which a chip select is low. `rsp_valid` pulses for one cycle at the edge that releases the chip select, with `rsp_err`=0. `rsp_rdata` equals `mem_din` sampled at that edge. A new request can be accepted in the `rsp_valid` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken when valid |
| req_addr | input | 32 | CPU byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion was an unmapped address |
| rsp_rdata | output | 32 | Read data captured at release |
| cfg_width | input | 16 | Width code, two bits per window |
| cfg_acc | input | 24 | Access-length code, three bits per window |
| cfg_wait_en | input | 8 | Wait input honoured, one bit per window |
| mem_ncs | output | 8 | Active-low chip selects, one per window |
| mem_addr | output | 27 | External address lines |
| mem_noe | output | 1 | Active-low read strobe |
| mem_nwe | output | 1 | Active-low write strobe |
| mem_dout | output | 32 | Write data to the bus |
| mem_doe | output | 1 | Bus data driver enable |
| mem_din | input | 32 | Read data from the bus |
| mem_nwait | input | 1 | Active-low wait from the device, synchronous to clk |

## Verification
Two events can land on the same clock edge. The first pair is the release of one access and the acceptance of the next: back-to-back requests are issued with no gap, and the test checks that each response reports the correct window, address, strobe kind and low time. The second pair is the expiry of the programmed count and a wait that is still asserted. The wait is held low and then released either before or after the count expires. The measured chip-select low time must be the larger of the programmed length and the release point. With the enable cleared, the low time must not change at all.

// File: rtl/stmem_pkg.sv
package stmem_pkg;

  localparam int WID_CODE_W = 2;
  localparam int ACC_CODE_W = 3;
  localparam int CNT_W      = 4;

  typedef enum logic [1:0] {
    BW_BYTE     = 2'b00,
    BW_HALF     = 2'b01,
    BW_WORD     = 2'b10,
    BW_WORD_ALT = 2'b11
  } bus_width_e;

  typedef enum logic {
    SEQ_IDLE   = 1'b0,
    SEQ_ACTIVE = 1'b1
  } seq_state_e;

  // Right-shift applied to the window offset; byte width is refused where
  // no_byte is set and falls back to half-word.
  function automatic logic [1:0] width_shift(input logic [1:0] code, input logic no_byte);
    case (bus_width_e'(code))
      BW_BYTE: width_shift = no_byte ? 2'd1 : 2'd0;
      BW_HALF: width_shift = 2'd1;
      default: width_shift = 2'd2;
    endcase
  endfunction

  // Chip-select low time in clocks for each access code.
  function automatic logic [CNT_W-1:0] access_clocks(input logic [ACC_CODE_W-1:0] code);
    case (code)
      3'd0:    access_clocks = 4'd1;
      3'd1:    access_clocks = 4'd2;
      3'd2:    access_clocks = 4'd3;
      3'd3:    access_clocks = 4'd4;
      3'd4:    access_clocks = 4'd6;
      3'd5:    access_clocks = 4'd8;
      3'd6:    access_clocks = 4'd10;
      default: access_clocks = 4'd14;
    endcase
  endfunction

endpackage

// File: rtl/stmem_bank_decode.sv
module stmem_bank_decode #(
  parameter int ADDR_W  = 32,
  parameter int NBANK   = 8,
  parameter int BANK_AW = 27,
  localparam int BSEL_W = $clog2(NBANK)
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic               hit,
  output logic [BSEL_W-1:0]  bank_idx,
  output logic [NBANK-1:0]   bank_sel,
  output logic [BANK_AW-1:0] offset
);
  localparam int TOP_LSB = BANK_AW + BSEL_W;

  assign hit      = (addr[ADDR_W-1:TOP_LSB] == '0);
  assign bank_idx = addr[TOP_LSB-1:BANK_AW];
  assign offset   = addr[BANK_AW-1:0];

  for (genvar i = 0; i < NBANK; i++) begin : g_sel
    assign bank_sel[i] = (bank_idx == BSEL_W'(i));
  end
endmodule

// File: rtl/stmem_cfg_pick.sv
module stmem_cfg_pick
  import stmem_pkg::*;
#(
  parameter int NBANK = 8,
  localparam int BSEL_W = $clog2(NBANK)
) (
  input  logic [WID_CODE_W*NBANK-1:0] cfg_width,
  input  logic [ACC_CODE_W*NBANK-1:0] cfg_acc,
  input  logic [NBANK-1:0]            cfg_wait_en,
  input  logic [BSEL_W-1:0]           bank_idx,
  output logic [1:0]                  shift,
  output logic [CNT_W-1:0]            clocks,
  output logic                        wait_en
);
  logic [1:0]       shift_b  [NBANK];
  logic [CNT_W-1:0] clocks_b [NBANK];

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    if (i == 0) begin : g_boot
      assign shift_b[i] = width_shift(cfg_width[WID_CODE_W*i +: WID_CODE_W], 1'b1);
    end else begin : g_plain
      assign shift_b[i] = width_shift(cfg_width[WID_CODE_W*i +: WID_CODE_W], 1'b0);
    end
    assign clocks_b[i] = access_clocks(cfg_acc[ACC_CODE_W*i +: ACC_CODE_W]);
  end

  assign shift   = shift_b[bank_idx];
  assign clocks  = clocks_b[bank_idx];
  assign wait_en = cfg_wait_en[bank_idx];
endmodule

// File: rtl/stmem_addr_shift.sv
module stmem_addr_shift #(
  parameter int BANK_AW = 27
) (
  input  logic [BANK_AW-1:0] offset,
  input  logic [1:0]         shift,
  output logic [BANK_AW-1:0] pin_addr
);
  always_comb begin
    case (shift)
      2'd0:    pin_addr = offset;
      2'd1:    pin_addr = {1'b0, offset[BANK_AW-1:1]};
      default: pin_addr = {2'b00, offset[BANK_AW-1:2]};
    endcase
  end
endmodule

// File: rtl/stmem_access_seq.sv
module stmem_access_seq
  import stmem_pkg::*;
#(
  parameter int NBANK   = 8,
  parameter int BANK_AW = 27,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic               req_hit,
  input  logic [NBANK-1:0]   req_sel,
  input  logic [BANK_AW-1:0] req_pin_addr,
  input  logic [CNT_W-1:0]   req_clocks,
  input  logic               req_wait_en,
  input  logic               mem_nwait,
  input  logic [DATA_W-1:0]  mem_din,
  output logic [NBANK-1:0]   mem_ncs,
  output logic [BANK_AW-1:0] mem_addr,
  output logic               mem_noe,
  output logic               mem_nwe,
  output logic [DATA_W-1:0]  mem_dout,
  output logic               mem_doe,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [DATA_W-1:0]  rsp_rdata
);
  seq_state_e       state;
  logic [CNT_W-1:0] remain;
  logic             wait_on;
  logic             stalled;

  assign req_ready = (state == SEQ_IDLE);
  assign stalled   = wait_on && !mem_nwait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SEQ_IDLE;
      remain    <= '0;
      wait_on   <= 1'b0;
      mem_ncs   <= '1;
      mem_addr  <= '0;
      mem_noe   <= 1'b1;
      mem_nwe   <= 1'b1;
      mem_dout  <= '0;
      mem_doe   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (req_valid) begin
            if (req_hit) begin
              state    <= SEQ_ACTIVE;
              remain   <= req_clocks - CNT_W'(1);
              wait_on  <= req_wait_en;
              mem_ncs  <= ~req_sel;
              mem_addr <= req_pin_addr;
              mem_noe  <= req_write;
              mem_nwe  <= ~req_write;
              mem_doe  <= req_write;
              mem_dout <= req_wdata;
            end else begin
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b1;
            end
          end
        end
        default: begin
          if (remain != '0) begin
            remain <= remain - CNT_W'(1);
          end else if (!stalled) begin
            state     <= SEQ_IDLE;
            mem_ncs   <= '1;
            mem_noe   <= 1'b1;
            mem_nwe   <= 1'b1;
            mem_doe   <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b0;
            rsp_rdata <= mem_din;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/stmem_bank_ctrl.sv
module stmem_bank_ctrl
  import stmem_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int NBANK   = 8,
  parameter int BANK_AW = 27
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic                        req_write,
  input  logic [DATA_W-1:0]           req_wdata,
  output logic                        rsp_valid,
  output logic                        rsp_err,
  output logic [DATA_W-1:0]           rsp_rdata,
  input  logic [WID_CODE_W*NBANK-1:0] cfg_width,
  input  logic [ACC_CODE_W*NBANK-1:0] cfg_acc,
  input  logic [NBANK-1:0]            cfg_wait_en,
  output logic [NBANK-1:0]            mem_ncs,
  output logic [BANK_AW-1:0]          mem_addr,
  output logic                        mem_noe,
  output logic                        mem_nwe,
  output logic [DATA_W-1:0]           mem_dout,
  output logic                        mem_doe,
  input  logic [DATA_W-1:0]           mem_din,
  input  logic                        mem_nwait
);
  localparam int BSEL_W = $clog2(NBANK);

  logic               hit;
  logic [BSEL_W-1:0]  bank_idx;
  logic [NBANK-1:0]   bank_sel;
  logic [BANK_AW-1:0] offset;
  logic [1:0]         shift;
  logic [CNT_W-1:0]   clocks;
  logic               wait_en;
  logic [BANK_AW-1:0] pin_addr;

  stmem_bank_decode #(.ADDR_W(ADDR_W), .NBANK(NBANK), .BANK_AW(BANK_AW)) u_decode (
    .addr     (req_addr),
    .hit      (hit),
    .bank_idx (bank_idx),
    .bank_sel (bank_sel),
    .offset   (offset)
  );

  stmem_cfg_pick #(.NBANK(NBANK)) u_cfg (
    .cfg_width   (cfg_width),
    .cfg_acc     (cfg_acc),
    .cfg_wait_en (cfg_wait_en),
    .bank_idx    (bank_idx),
    .shift       (shift),
    .clocks      (clocks),
    .wait_en     (wait_en)
  );

  stmem_addr_shift #(.BANK_AW(BANK_AW)) u_shift (
    .offset   (offset),
    .shift    (shift),
    .pin_addr (pin_addr)
  );

  stmem_access_seq #(.NBANK(NBANK), .BANK_AW(BANK_AW), .DATA_W(DATA_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_write    (req_write),
    .req_wdata    (req_wdata),
    .req_hit      (hit),
    .req_sel      (bank_sel),
    .req_pin_addr (pin_addr),
    .req_clocks   (clocks),
    .req_wait_en  (wait_en),
    .mem_nwait    (mem_nwait),
    .mem_din      (mem_din),
    .mem_ncs      (mem_ncs),
    .mem_addr     (mem_addr),
    .mem_noe      (mem_noe),
    .mem_nwe      (mem_nwe),
    .mem_dout     (mem_dout),
    .mem_doe      (mem_doe),
    .rsp_valid    (rsp_valid),
    .rsp_err      (rsp_err),
    .rsp_rdata    (rsp_rdata)
  );
endmodule

// File: rtl/stmem_bank_ctrl_chk.sv
module stmem_bank_ctrl_chk #(
  parameter int ADDR_W  = 32,
  parameter int NBANK   = 8,
  parameter int BANK_AW = 27,
  localparam int TOP_LSB = BANK_AW + $clog2(NBANK)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [ADDR_W-1:0]  req_addr,
  input logic               rsp_valid,
  input logic               rsp_err,
  input logic [NBANK-1:0]   mem_ncs,
  input logic [BANK_AW-1:0] mem_addr,
  input logic               mem_noe,
  input logic               mem_nwe
);
  logic busy;
  assign busy = !(&mem_ncs);

  p_single_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_ncs));

  p_unmapped_no_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_addr[ADDR_W-1:TOP_LSB] != '0))
      |=> (&mem_ncs && rsp_valid && rsp_err));

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(mem_addr) && $stable(mem_ncs)));

  p_strobe_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |-> (mem_noe && mem_nwe));

  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_noe && !mem_nwe));

  p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  p_rsp_at_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err) |-> (!busy && $past(busy)));
endmodule

bind stmem_bank_ctrl stmem_bank_ctrl_chk #(
  .ADDR_W(ADDR_W), .NBANK(NBANK), .BANK_AW(BANK_AW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .mem_ncs   (mem_ncs),
  .mem_addr  (mem_addr),
  .mem_noe   (mem_noe),
  .mem_nwe   (mem_nwe)
);

// File: tb/stmem_bank_ctrl_test.sv
module stmem_bank_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [31:0] req_addr, req_wdata;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [15:0] cfg_width;
  logic [23:0] cfg_acc;
  logic [7:0]  cfg_wait_en;
  logic [7:0]  mem_ncs;
  logic [26:0] mem_addr;
  logic        mem_noe, mem_nwe, mem_doe, mem_nwait;
  logic [31:0] mem_dout, mem_din;

  always #2 clk = ~clk;

  assign mem_din = {5'b10110, mem_addr};

  stmem_bank_ctrl uut (.*);

  typedef struct {
    bit          err;
    bit          wr;
    logic [7:0]  ncs;
    logic [26:0] addr;
    logic [31:0] data;
    int          cycles;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;

  function automatic int clocks_of(input logic [2:0] c);
    case (c)
      3'd0: return 1;  3'd1: return 2;  3'd2: return 3;  3'd3: return 4;
      3'd4: return 6;  3'd5: return 8;  3'd6: return 10; default: return 14;
    endcase
  endfunction

  function automatic int shift_for(input int b, input logic [1:0] w);
    if (w == 2'b00) return (b == 0) ? 1 : 0;
    if (w == 2'b01) return 1;
    return 2;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_bank(input int b, input logic [1:0] w, input logic [2:0] a, input bit we);
    cfg_width[2*b +: 2] = w;
    cfg_acc[3*b +: 3]   = a;
    cfg_wait_en[b]      = we;
  endtask

  task automatic issue(input logic [31:0] a, input bit wr, input logic [31:0] wd,
                       input int floor_cyc, input string tag);
    exp_t e;
    int   b;
    b        = int'(a[29:27]);
    e.err    = (a[31:30] != 2'b00);
    e.wr     = wr;
    e.ncs    = ~(8'b1 << b);
    e.addr   = a[26:0] >> shift_for(b, cfg_width[2*b +: 2]);
    e.cycles = clocks_of(cfg_acc[3*b +: 3]);
    if (floor_cyc > e.cycles) e.cycles = floor_cyc;
    e.data   = wr ? wd : {5'b10110, e.addr};
    e.tag    = tag;
    q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: measures each access at the pins and compares on completion.
  int          run = 0;
  logic [7:0]  s_ncs;
  logic [26:0] s_addr;
  logic        s_noe, s_nwe, s_doe;
  logic [31:0] s_dout;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (!(&mem_ncs)) begin
        if (run == 0) begin
          s_ncs = mem_ncs; s_addr = mem_addr; s_noe = mem_noe;
          s_nwe = mem_nwe; s_doe = mem_doe; s_dout = mem_dout;
        end
        run++;
      end
      if (rsp_valid) begin
        if (q.size() == 0) begin
          check(1'b0, "R8 unexpected response", 32'(rsp_err), 32'hFFFF_FFFF);
        end else begin
          exp_t e;
          bit   ok;
          logic [31:0] got;
          e = q.pop_front();
          if (e.err) begin
            ok  = rsp_err && (run == 0);
            got = 32'(rsp_err);
          end else begin
            got = e.wr ? s_dout : rsp_rdata;
            ok  = !rsp_err && (run == e.cycles) && (s_ncs == e.ncs) && (s_addr == e.addr) &&
                  (e.wr ? (!s_nwe && s_noe && s_doe && s_dout == e.data)
                        : (!s_noe && s_nwe && !s_doe && rsp_rdata == e.data));
          end
          n_chk++;
          if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual err=%0b cyc=%0d ncs=%h addr=%h data=%h expected err=%0b cyc=%0d ncs=%h addr=%h data=%h",
                     e.tag, rsp_err, run, s_ncs, s_addr, got,
                     e.err, e.err ? 0 : e.cycles, e.ncs, e.addr, e.data);
          end
        end
        run = 0;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    int cnt;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_wdata = '0;
    mem_nwait = 1'b1;
    cfg_width = {8{2'b10}}; cfg_acc = {8{3'd7}}; cfg_wait_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(mem_ncs == 8'hFF, "R1 chip selects", 32'(mem_ncs), 32'hFF);
    check(mem_noe && mem_nwe && !mem_doe, "R1 strobes", {29'd0, mem_noe, mem_nwe, mem_doe}, 32'h6);
    check(!rsp_valid && req_ready, "R1 handshake", {30'd0, rsp_valid, req_ready}, 32'h1);

    // R4 R5: window 0 code 00 acts as 16-bit, code 7 = 14 clocks
    set_bank(0, 2'b00, 3'd7, 1'b0);
    issue(32'h0000_0106, 1'b0, '0, 0, "R4 R5 bank0 byte refused, 14 clocks");
    drain();
    // R3 R8: 32-bit, 1 clock; ready low exactly the access length
    set_bank(0, 2'b10, 3'd0, 1'b0);
    issue(32'h0000_0104, 1'b0, '0, 0, "R3 bank0 word 1 clock");
    cnt = 0;
    while (!req_ready) begin cnt++; @(negedge clk); end
    check(cnt == 1, "R8 ready low span", 32'(cnt), 32'd1);
    drain();
    // R2 R3: window 6 32-bit, code 1
    set_bank(6, 2'b10, 3'd1, 1'b0);
    issue(32'h3000_1000, 1'b0, '0, 0, "R2 R3 bank6 word");
    drain();
    // R3: window 3 8-bit, code 2
    set_bank(3, 2'b00, 3'd2, 1'b0);
    issue(32'h1800_0ABC, 1'b0, '0, 0, "R3 bank3 byte unshifted");
    // R6: write on window 5 16-bit, code 4
    set_bank(5, 2'b01, 3'd4, 1'b0);
    issue(32'h2800_0010, 1'b1, 32'hCAFE_1234, 0, "R6 bank5 half write");
    cnt = 0;
    while (!req_ready) begin cnt++; @(negedge clk); end
    check(cnt == 6, "R8 ready low span write", 32'(cnt), 32'd6);
    drain();
    // R3: top of window 7 with code 11 as 32-bit
    set_bank(7, 2'b11, 3'd5, 1'b0);
    issue(32'h3FFF_FFFC, 1'b0, '0, 0, "R3 bank7 top word");
    // R2: unmapped addresses complete with error
    issue(32'h4000_0000, 1'b0, '0, 0, "R2 unmapped low edge");
    issue(32'hFFFF_FFFC, 1'b1, 32'h1, 0, "R2 unmapped top");
    drain();
    // R8: back-to-back on different windows
    issue(32'h3000_0040, 1'b1, 32'h0BAD_F00D, 0, "R8 back-to-back first");
    issue(32'h1800_0003, 1'b0, '0, 0, "R8 back-to-back second");
    issue(32'h0000_0008, 1'b0, '0, 0, "R8 back-to-back third");
    drain();
    // R7: wait enabled, released late -> stretched to release point
    set_bank(2, 2'b10, 3'd3, 1'b1);
    mem_nwait = 1'b0;
    issue(32'h1000_0200, 1'b0, '0, 10, "R7 wait stretches to 10");
    repeat (9) @(negedge clk);
    mem_nwait = 1'b1;
    drain();
    // R7: wait released before count expires -> programmed length
    mem_nwait = 1'b0;
    issue(32'h1000_0300, 1'b1, 32'h5555_AAAA, 0, "R7 early release keeps 4");
    @(negedge clk);
    mem_nwait = 1'b1;
    drain();
    // R7: wait ignored when disabled for the window
    set_bank(1, 2'b01, 3'd6, 1'b0);
    mem_nwait = 1'b0;
    issue(32'h0800_0022, 1'b0, '0, 0, "R7 wait ignored when disabled");
    drain();
    mem_nwait = 1'b1;
    check(q.size() == 0, "R8 all responses seen", 32'(q.size()), 32'd0);
    finish_run();
  end
endmodule